// File: doc/BRIEF.md
# Vector Nibble-Indexed Table Lookup Unit

This unit builds a destination vector of `VL` bits by using packed 4-bit indices to look up entries in one or two table vectors. A two-bit segment selector picks which slice of the index vector supplies the indices. The slice is exactly as many nibbles as there are destination elements. Elements are 8 or 16 bits wide. In single-table mode the lookup reads the first table only. In two-table mode the 16 index values are split across the low 128 bits of both tables. There is no predication, so every destination element is written.

A request is taken when `in_valid` is high. The result and a one-cycle `out_valid` pulse appear one clock later. If the request uses a mode combination the unit does not support, the unit raises `illegal` for one cycle instead and leaves the result register as it was. The unit also outputs the register number of the second table, which is the first table's number plus one, wrapping at 32. The register-file side uses this number to fetch the second table.

Top module: `nib_lut_unit`

## Requirements
- R1: After reset, `out_valid` and `illegal` are 0 and `out_vec` is all zero.
- R2: A legal request taken on a rising edge produces `out_valid` = 1 with the result during the following cycle only. Back-to-back requests give back-to-back results.
- R3: With `wide_mode` = 0 (8-bit elements), there are VL/8 elements. Byte e of `out_vec` is byte number k of `tbl_a`, where k is the nibble at position (VL/8)·`seg_sel[0]` + e of `idx_vec`. Nibble p occupies bits 4p+3..4p.
- R4: With `wide_mode` = 0, only segments 0 and 1 exist. A request with `seg_sel[1]` = 1 is illegal.
- R5: With `wide_mode` = 1 and `dual_mode` = 0 (allowed only when VL ≥ 256), there are VL/16 elements. Halfword e of `out_vec` is halfword k of the low 256 bits of `tbl_a`, where k is the nibble at position (VL/16)·`seg_sel` + e. `tbl_b` has no effect.
- R6: With `wide_mode` = 1 and `dual_mode` = 1, an index k below 8 selects halfword k of `tbl_a`. Any other index selects halfword k−8 of `tbl_b`. Table bits above bit 127 have no effect.
- R7: In 8-bit mode, `tbl_b` and the bits of `tbl_a` above bit 127 have no effect on the result.
- R8: `dual_mode` = 1 together with `wide_mode` = 0 is illegal.
- R9: When VL < 256, `wide_mode` = 1 with `dual_mode` = 0 is illegal.
- R10: An illegal request gives `illegal` = 1 for the next cycle only, keeps `out_valid` at 0 and leaves `out_vec` unchanged.
- R11: `tbl2_reg_num` equals (`tbl_reg_num` + 1) mod 32 at all times. This includes 31 wrapping to 0.
- R12: In a cycle after which no request was taken, `out_valid` and `illegal` are 0 and `out_vec` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; inputs are sampled when high |
| idx_vec | input | VL | Packed 4-bit index vector |
| tbl_a | input | VL | First table vector |
| tbl_b | input | VL | Second table vector (two-table mode) |
| seg_sel | input | 2 | Index segment selector |
| wide_mode | input | 1 | 0: 8-bit elements, 1: 16-bit elements |
| dual_mode | input | 1 | 1: lookup spans two tables |
| tbl_reg_num | input | 5 | Register number of the first table |
| tbl2_reg_num | output | 5 | Register number of the second table |
| out_valid | output | 1 | Result valid pulse |
| illegal | output | 1 | Illegal-configuration pulse |
| out_vec | output | VL | Result vector register |

## Verification
The embedded assertions check the cycle-by-cycle behaviour on every cycle. These checks cover:
- `out_valid` and `illegal` only ever follow a strobe, and they never appear together.
- The result register stays still on idle and rejected cycles.
- A two-table byte request or an out-of-range byte segment is always flagged.
- The second register number wraps from 31 to 0.

The element contents need the bench's own scenarios. These are the segment offsets in each mode, the split between the tables at index 8, and the insensitivity to `tbl_b` and to the upper table bits. The scenarios also cover the rejection of the single-table 16-bit mode at a 128-bit vector length.

// File: rtl/nlut_pkg.sv
package nlut_pkg;

  // 8-bit element from a 16-entry table (low 128 bits)
  function automatic logic [7:0] pick_byte(input logic [127:0] t, input logic [3:0] n);
    return t[{n, 3'b000} +: 8];
  endfunction

  // 16-bit element: single table of 16 entries, or two tables of 8 entries
  function automatic logic [15:0] pick_half(input logic [255:0] ta, input logic [127:0] tb,
                                            input logic [3:0] n, input logic dual);
    if (dual) begin
      if (n[3]) return tb[{n[2:0], 4'b0000} +: 16];
      else      return ta[{n[2:0], 4'b0000} +: 16];
    end
    return ta[{n, 4'b0000} +: 16];
  endfunction

  // Mode legality
  function automatic logic cfg_bad(input logic wide, input logic dual,
                                   input logic [1:0] seg, input logic vl_has_256);
    return (dual && !wide) || (!wide && seg[1]) || (wide && !dual && !vl_has_256);
  endfunction

  function automatic logic [4:0] next_reg(input logic [4:0] r);
    return r + 5'd1;
  endfunction

endpackage

// File: rtl/nlut_mode_chk.sv
module nlut_mode_chk #(
  parameter int VL = 256
) (
  input  logic       wide,
  input  logic       dual,
  input  logic [1:0] seg,
  output logic       bad
);
  import nlut_pkg::*;
  localparam logic VL_HAS_256 = (VL >= 256);

  always_comb bad = cfg_bad(wide, dual, seg, VL_HAS_256);
endmodule

// File: rtl/nlut_seg_extract.sv
module nlut_seg_extract #(
  parameter int VL = 256
) (
  input  logic [VL-1:0]   idx_vec,
  input  logic [1:0]      seg,
  output logic [VL/2-1:0] byte_nibs,
  output logic [VL/4-1:0] half_nibs
);
  localparam int HB = VL / 2;  // nibble bits per byte-mode segment
  localparam int QB = VL / 4;  // nibble bits per halfword-mode segment

  always_comb byte_nibs = seg[0] ? idx_vec[VL-1:HB] : idx_vec[HB-1:0];

  always_comb begin
    half_nibs = '0;
    for (int k = 0; k < 4; k++) begin
      if (seg == k[1:0]) half_nibs = idx_vec[k*QB +: QB];
    end
  end
endmodule

// File: rtl/nlut_lookup.sv
module nlut_lookup #(
  parameter int VL = 256
) (
  input  logic [VL/2-1:0] byte_nibs,
  input  logic [VL/4-1:0] half_nibs,
  input  logic [VL-1:0]   tbl_a,
  input  logic [VL-1:0]   tbl_b,
  input  logic            wide,
  input  logic            dual,
  output logic [VL-1:0]   res
);
  import nlut_pkg::*;
  localparam int NB = VL / 8;
  localparam int NH = VL / 16;

  logic [255:0]  ta_ext;
  logic [127:0]  ta_lo;
  logic [127:0]  tb_lo;
  logic [VL-1:0] byte_res;
  logic [VL-1:0] half_res;

  generate
    if (VL >= 256) begin : g_wide_tbl
      assign ta_ext = tbl_a[255:0];
    end else begin : g_narrow_tbl
      assign ta_ext = {{(256-VL){1'b0}}, tbl_a};
    end
  endgenerate

  assign ta_lo = tbl_a[127:0];
  assign tb_lo = tbl_b[127:0];

  generate
    for (genvar e = 0; e < NB; e++) begin : g_byte
      assign byte_res[8*e +: 8] = pick_byte(ta_lo, byte_nibs[4*e +: 4]);
    end
    for (genvar e = 0; e < NH; e++) begin : g_half
      assign half_res[16*e +: 16] = pick_half(ta_ext, tb_lo, half_nibs[4*e +: 4], dual);
    end
  endgenerate

  assign res = wide ? half_res : byte_res;
endmodule

// File: rtl/nib_lut_unit.sv
module nib_lut_unit #(
  parameter int VL = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VL-1:0] idx_vec,
  input  logic [VL-1:0] tbl_a,
  input  logic [VL-1:0] tbl_b,
  input  logic [1:0]    seg_sel,
  input  logic          wide_mode,
  input  logic          dual_mode,
  input  logic [4:0]    tbl_reg_num,
  output logic [4:0]    tbl2_reg_num,
  output logic          out_valid,
  output logic          illegal,
  output logic [VL-1:0] out_vec
);
  import nlut_pkg::*;

  logic [VL/2-1:0] byte_nibs;
  logic [VL/4-1:0] half_nibs;
  logic [VL-1:0]   lut_res;
  logic            cfg_is_bad;
  logic            take_req;   // legal request accepted this edge
  logic            reject_req; // illegal request seen this edge

  nlut_mode_chk #(.VL(VL)) u_chk (
    .wide(wide_mode), .dual(dual_mode), .seg(seg_sel), .bad(cfg_is_bad)
  );

  nlut_seg_extract #(.VL(VL)) u_seg (
    .idx_vec(idx_vec), .seg(seg_sel), .byte_nibs(byte_nibs), .half_nibs(half_nibs)
  );

  nlut_lookup #(.VL(VL)) u_lut (
    .byte_nibs(byte_nibs), .half_nibs(half_nibs), .tbl_a(tbl_a), .tbl_b(tbl_b),
    .wide(wide_mode), .dual(dual_mode), .res(lut_res)
  );

  assign take_req     = in_valid && !cfg_is_bad;
  assign reject_req   = in_valid && cfg_is_bad;
  assign tbl2_reg_num = next_reg(tbl_reg_num);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= take_req;
      illegal   <= reject_req;
      if (take_req) out_vec <= lut_res;
    end
  end

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R2
  AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && illegal)); // R10
  AST_HOLD_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(out_vec)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!out_valid && !illegal && $stable(out_vec))); // R12
  AST_DUAL_BYTE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dual_mode && !wide_mode) |=> illegal); // R8
  AST_BYTE_SEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_mode && seg_sel[1]) |=> illegal); // R4
  AST_REG_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_reg_num == 5'd31) |-> (tbl2_reg_num == 5'd0)); // R11
endmodule

// File: tb/nib_lut_unit_test.sv
module nib_lut_unit_test;
  localparam int VL  = 256;
  localparam int VLS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          in_valid = 0;
  logic [VL-1:0] idx_vec = '0, tbl_a = '0, tbl_b = '0;
  logic [1:0]    seg_sel = 0;
  logic          wide_mode = 0, dual_mode = 0;
  logic [4:0]    tbl_reg_num = 0;
  logic [4:0]    tbl2_reg_num;
  logic          out_valid, illegal;
  logic [VL-1:0] out_vec;

  logic           s_valid_o, s_illegal;
  logic [4:0]     s_reg2;
  logic [VLS-1:0] s_out;

  int checks = 0;
  int errors = 0;

  nib_lut_unit #(.VL(VL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .idx_vec(idx_vec), .tbl_a(tbl_a),
    .tbl_b(tbl_b), .seg_sel(seg_sel), .wide_mode(wide_mode), .dual_mode(dual_mode),
    .tbl_reg_num(tbl_reg_num), .tbl2_reg_num(tbl2_reg_num), .out_valid(out_valid),
    .illegal(illegal), .out_vec(out_vec)
  );

  nib_lut_unit #(.VL(VLS)) uut_small (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .idx_vec(idx_vec[VLS-1:0]),
    .tbl_a(tbl_a[VLS-1:0]), .tbl_b(tbl_b[VLS-1:0]), .seg_sel(seg_sel),
    .wide_mode(wide_mode), .dual_mode(dual_mode), .tbl_reg_num(tbl_reg_num),
    .tbl2_reg_num(s_reg2), .out_valid(s_valid_o), .illegal(s_illegal), .out_vec(s_out)
  );

  // Independent model: walk elements, shift tables right by index * width
  function automatic logic [255:0] model(input int vl, input logic [255:0] iv,
      input logic [255:0] ta, input logic [255:0] tb, input int seg,
      input bit wide, input bit dual);
    logic [255:0] r = '0;
    int ew = wide ? 16 : 8;
    int ne = vl / ew;
    for (int e = 0; e < ne; e++) begin
      int pos = ne * seg + e;
      int k = int'((iv >> (4 * pos)) & 256'hF);
      logic [255:0] v;
      if (!wide)               v = (ta >> (8 * k)) & 256'hFF;
      else if (!dual || k < 8) v = (ta >> (16 * k)) & 256'hFFFF;
      else                     v = (tb >> (16 * (k - 8))) & 256'hFFFF;
      r = r | (v << (ew * e));
    end
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One-cycle request; returns at the negedge after the capturing edge
  task automatic send(input logic [1:0] s, input bit w, input bit d);
    @(negedge clk);
    seg_sel = s; wide_mode = w; dual_mode = d; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", {255'd0, out_valid}, 256'd0);
    chk("R1 illegal", {255'd0, illegal}, 256'd0);
    chk("R1 out_vec", out_vec, 256'd0);
  endtask

  task automatic t_byte(input int s);
    idx_vec = rnd256(); tbl_a = rnd256(); tbl_b = rnd256();
    send(s[1:0], 0, 0);
    chk("R2 valid", {255'd0, out_valid}, 256'd1);
    chk($sformatf("R3 byte seg%0d", s), out_vec, model(VL, idx_vec, tbl_a, tbl_b, s, 0, 0));
    @(negedge clk);
    chk("R2 pulse ends", {255'd0, out_valid}, 256'd0);
  endtask

  task automatic t_half_single(input int s);
    idx_vec = rnd256(); tbl_a = rnd256(); tbl_b = rnd256();
    send(s[1:0], 1, 0);
    chk("R5 valid", {255'd0, out_valid}, 256'd1);
    chk($sformatf("R5 half seg%0d", s), out_vec, model(VL, idx_vec, tbl_a, tbl_b, s, 1, 0));
  endtask

  task automatic t_half_dual(input int s);
    idx_vec = rnd256(); tbl_a = rnd256(); tbl_b = rnd256();
    send(s[1:0], 1, 1);
    chk($sformatf("R6 dual seg%0d", s), out_vec, model(VL, idx_vec, tbl_a, tbl_b, s, 1, 1));
  endtask

  task automatic t_dual_split();
    // Segment 0 index nibbles 0..15 in order: covers both tables exactly
    logic [255:0] exp = '0;
    idx_vec = '0;
    for (int i = 0; i < 16; i++) idx_vec[4*i +: 4] = i[3:0];
    for (int i = 0; i < 8; i++) begin
      tbl_a[16*i +: 16] = 16'hA000 + 16'(i);
      tbl_b[16*i +: 16] = 16'hB000 + 16'(i);
      exp[16*i +: 16] = 16'hA000 + 16'(i);
      exp[16*(i+8) +: 16] = 16'hB000 + 16'(i);
    end
    tbl_a[255:128] = '1; tbl_b[255:128] = '1;
    send(2'd0, 1, 1);
    chk("R6 split at 8", out_vec, exp);
  endtask

  task automatic t_byte_ignore();
    logic [255:0] first;
    idx_vec = rnd256(); tbl_a = rnd256(); tbl_b = rnd256();
    send(2'd1, 0, 0);
    first = out_vec;
    tbl_b = ~tbl_b; tbl_a[255:128] = ~tbl_a[255:128];
    send(2'd1, 0, 0);
    chk("R7 tbl_b/upper ignored", out_vec, first);
    tbl_b = rnd256();
    send(2'd2, 1, 0);
    first = out_vec;
    tbl_b = ~tbl_b;
    send(2'd2, 1, 0);
    chk("R5 tbl_b ignored", out_vec, first);
  endtask

  task automatic t_illegal(input string req, input logic [1:0] s, input bit w, input bit d);
    logic [255:0] held = out_vec;
    idx_vec = rnd256(); tbl_a = rnd256();
    send(s, w, d);
    chk({req, " flag"}, {255'd0, illegal}, 256'd1);
    chk("R10 no valid", {255'd0, out_valid}, 256'd0);
    chk("R10 out held", out_vec, held);
    @(negedge clk);
    chk("R10 flag pulse", {255'd0, illegal}, 256'd0);
  endtask

  task automatic t_small_vl();
    idx_vec = rnd256(); tbl_a = rnd256(); tbl_b = rnd256();
    send(2'd1, 1, 0);
    chk("R9 small flag", {255'd0, s_illegal}, 256'd1);
    chk("R9 small no valid", {255'd0, s_valid_o}, 256'd0);
    send(2'd3, 1, 1);
    chk("R6 small dual", {128'd0, s_out},
        model(VLS, {128'd0, idx_vec[127:0]}, {128'd0, tbl_a[127:0]},
              {128'd0, tbl_b[127:0]}, 3, 1, 1));
    send(2'd0, 0, 0);
    chk("R3 small byte", {128'd0, s_out},
        model(VLS, {128'd0, idx_vec[127:0]}, {128'd0, tbl_a[127:0]}, '0, 0, 0, 0));
  endtask

  task automatic t_idle();
    logic [255:0] held = out_vec;
    idx_vec = rnd256(); tbl_a = rnd256();
    repeat (3) @(negedge clk);
    chk("R12 idle valid", {254'd0, out_valid, illegal}, 256'd0);
    chk("R12 idle hold", out_vec, held);
  endtask

  task automatic t_back_to_back();
    logic [255:0] i1, i2, e2;
    i1 = rnd256(); i2 = rnd256(); tbl_a = rnd256();
    @(negedge clk);
    idx_vec = i1; seg_sel = 0; wide_mode = 0; dual_mode = 0; in_valid = 1;
    @(negedge clk);
    chk("R2 first", out_vec, model(VL, i1, tbl_a, tbl_b, 0, 0, 0));
    idx_vec = i2; seg_sel = 3; wide_mode = 1;
    e2 = model(VL, i2, tbl_a, tbl_b, 3, 1, 0);
    @(negedge clk);
    in_valid = 0;
    chk("R2 second", out_vec, e2);
    chk("R2 second valid", {255'd0, out_valid}, 256'd1);
  endtask

  task automatic t_regnum();
    for (int r = 0; r < 32; r += 5) begin
      tbl_reg_num = r[4:0];
      #1;
      chk("R11 next reg", {251'd0, tbl2_reg_num}, 256'((r + 1) % 32));
    end
    tbl_reg_num = 5'd31;
    #1;
    chk("R11 wrap", {251'd0, tbl2_reg_num}, 256'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    for (int s = 0; s < 2; s++) t_byte(s);
    for (int s = 0; s < 4; s++) t_half_single(s);
    for (int s = 0; s < 4; s++) t_half_dual(s);
    t_dual_split();
    t_byte_ignore();
    t_illegal("R8", 2'd0, 0, 1);
    t_illegal("R4", 2'd2, 0, 0);
    t_illegal("R4", 2'd3, 0, 0);
    t_small_vl();
    t_idle();
    t_back_to_back();
    t_regnum();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule